// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits on the controller side of a synchronous DRAM. It turns one read or write command into a run of column addresses, presenting one beat per clock. Each command carries a bank and a starting column. A small mode register sets how the burst runs: the number of beats, whether columns wrap sequentially or interleaved, and the read latency. Write beats are flagged as write-data-valid in the same cycle as their column. Read beats produce a read-data-valid flag a fixed latency later, which lines up with the moment data returns from the memory.

A burst can be stopped early by a terminate command, or it can be replaced on any cycle by a new read or write. In both cases read beats that were already issued still produce their delayed valid flags. Mode writes are only accepted while no beat is being issued. A mode write that arrives at a bad time, or that asks for an illegal setting, changes nothing and raises a one-cycle error flag.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, beat_valid, wr_data_valid, rd_data_valid and mode_err are low. The mode after reset is 1 beat, sequential order, latency 2.
- R2: A read (cmd_op=1) or write (cmd_op=2) presented in cycle c produces its first beat in cycle c+1. That beat carries the command's column and bank, and the burst then issues one beat per cycle. wr_data_valid is high exactly in the cycles of write beats.
- R3: The length code sets the number of beats: code 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. After the last beat, beat_valid falls.
- R4: In sequential order, beat k has column base + ((s mod L) + k) mod L. Here s is the start column, L is the length and base is s rounded down to a multiple of L.
- R5: In interleaved order (mode_interleave=1), beat k has column base + ((s mod L) XOR k).
- R6: Length code 7 selects full page, only together with sequential order. The column steps upward over all 256 columns, wraps from 255 to 0, and continues until a terminate or a new command arrives.
- R7: A terminate (cmd_op=3) in cycle c means no beat in cycle c+1. A terminate while idle has no effect.
- R8: A read or write presented during a burst ends that burst. A fresh burst with the new bank, column and direction starts in the next cycle.
- R9: The bank shown on beat_bank stays constant for all beats of one burst.
- R10: A read beat in cycle b gives rd_data_valid high in cycle b+CL-1, where CL is 2 when mode_cl3=0 and 3 when mode_cl3=1. So the first valid comes CL cycles after the command. Beats already issued still produce their valid after a terminate or an interrupting command.
- R11: A mode write in a cycle where a beat is being issued, or where a read or write command is presented, is ignored. mode_err is then high in the next cycle.
- R12: A mode write with length code 4, 5 or 6, or with code 7 together with interleaved order, is ignored, and mode_err is high in the next cycle. A legal mode write while idle takes effect for the next command, and mode_err stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Request to load the mode fields below |
| mode_len_code | input | 3 | Burst length code (0..3 = 1,2,4,8 beats; 7 = full page) |
| mode_interleave | input | 1 | 1 = interleaved column order |
| mode_cl3 | input | 1 | 1 = read latency 3, 0 = read latency 2 |
| cmd_op | input | 2 | 0 none, 1 read, 2 write, 3 terminate |
| cmd_bank | input | BANK_W | Bank of a read or write command |
| cmd_col | input | COL_W | Starting column of a read or write command |
| beat_valid | output | 1 | A burst beat is issued this cycle |
| beat_bank | output | BANK_W | Bank of the current beat |
| beat_col | output | COL_W | Column of the current beat |
| wr_data_valid | output | 1 | Current beat is a write beat |
| rd_data_valid | output | 1 | Read data for an earlier beat is due this cycle |
| mode_err | output | 1 | Previous cycle's mode write was rejected |

## Verification
A corrupted beat index or start column shows up on beat_col in the same cycle it occurs, because the column is formed directly from the burst state. A wrong remaining-length decision shows as beat_valid high or low one cycle off at the end of the burst. A fault in the read pipeline surfaces only CL-1 cycles after the beat that caused it, so the reference model schedules each expected read-valid at issue time. A mode register that took a rejected write stays hidden until the next command, where it changes length, order or latency. For that reason the sequence always issues a command after each rejected write.

// File: rtl/sdram_burst_pkg.sv
// Shared command encoding and mode settings for the burst column sequencer.
package sdram_burst_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_TERM  = 2'd3
    } burst_op_e;

    localparam logic [2:0] LEN_CODE_FULL = 3'd7;
    localparam logic [2:0] LEN_CODE_MAX  = 3'd3;

    typedef struct packed {
        logic [2:0] len_code;
        logic       interleave;
        logic       cl3;
    } burst_mode_t;

endpackage

// File: rtl/sdram_burst_mode.sv
// Mode register. Loads a new setting only when no beat is issued and no
// command starts in the same cycle, and only if the setting is legal.
// Any rejected write raises a one-cycle error pulse.
// Assumes: burst_busy is high in every cycle in which a beat is issued.
module sdram_burst_mode
    import sdram_burst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_req,
    input  logic [2:0]  wr_len_code,
    input  logic        wr_interleave,
    input  logic        wr_cl3,
    input  logic        burst_busy,
    input  logic        cmd_starts,
    output burst_mode_t cfg,
    output logic        err
);

    logic legal;

    // Legality of the requested setting: fixed lengths always, full page only sequential.
    always_comb begin
        legal = (wr_len_code <= LEN_CODE_MAX) ||
                ((wr_len_code == LEN_CODE_FULL) && !wr_interleave);
    end

    // Mode storage and rejection pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{len_code: 3'd0, interleave: 1'b0, cl3: 1'b0};
            err <= 1'b0;
        end else begin
            err <= 1'b0;
            if (wr_req) begin
                if (burst_busy || cmd_starts || !legal) begin
                    err <= 1'b1;
                end else begin
                    cfg <= '{len_code: wr_len_code, interleave: wr_interleave, cl3: wr_cl3};
                end
            end
        end
    end

endmodule

// File: rtl/sdram_burst_addr.sv
// Burst state and column generator. Latches the bank, start column,
// direction and the burst shape when a command starts. It then steps a
// beat index, one beat per cycle, until the length runs out, a terminate
// arrives, or a new command replaces the burst.
// Assumes: COL_W >= 3 so that an 8-beat burst fits in the column.
module sdram_burst_addr
    import sdram_burst_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              start_read,
    input  logic [COL_W-1:0]  start_col,
    input  logic [BANK_W-1:0] start_bank,
    input  burst_mode_t       cfg,
    output logic              active,
    output logic              is_read,
    output logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] bank
);

    localparam int FIXED_BITS = 3;

    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] base_col_q;
    logic [COL_W-1:0] mask_q;
    logic             inter_q;
    logic             full_q;
    logic [COL_W-1:0] mask_n;
    logic             last_beat;
    logic [COL_W-1:0] low_bits;

    // Wrap mask for the configured length: low bits set, all bits for full page.
    always_comb begin
        mask_n = '0;
        if (cfg.len_code == LEN_CODE_FULL) begin
            mask_n = '1;
        end else begin
            for (int k = 0; k < FIXED_BITS; k++) begin
                if (k < int'(cfg.len_code)) mask_n[k] = 1'b1;
            end
        end
    end

    // End of a fixed-length burst is reached when the index covers the whole mask.
    always_comb begin
        last_beat = !full_q && (idx_q == mask_q);
    end

    // Column order: add or XOR the beat index inside the aligned block.
    always_comb begin
        if (inter_q) low_bits = base_col_q ^ idx_q;
        else         low_bits = base_col_q + idx_q;
        col = (base_col_q & ~mask_q) | (low_bits & mask_q);
    end

    // Burst state: load on a command, stop on terminate or at the end, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            is_read    <= 1'b0;
            idx_q      <= '0;
            base_col_q <= '0;
            mask_q     <= '0;
            inter_q    <= 1'b0;
            full_q     <= 1'b0;
            bank       <= '0;
        end else if (start) begin
            active     <= 1'b1;
            is_read    <= start_read;
            idx_q      <= '0;
            base_col_q <= start_col;
            mask_q     <= mask_n;
            inter_q    <= cfg.interleave;
            full_q     <= (cfg.len_code == LEN_CODE_FULL);
            bank       <= start_bank;
        end else if (stop) begin
            active <= 1'b0;
        end else if (active) begin
            if (last_beat) active <= 1'b0;
            else           idx_q  <= idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/sdram_burst_rdpipe.sv
// Read-valid delay line. A read beat enters at a stage chosen by the
// latency, so that its valid comes out 1 or 2 cycles after the beat.
// Beats already in the line keep moving whatever happens to the burst.
// Assumes: the latency does not change while a beat sits in the first stage.
module sdram_burst_rdpipe (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_read,
    input  logic cl3,
    output logic rd_valid
);

    logic stage_early;

    // Shift stages: latency 3 enters one stage earlier than latency 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_early <= 1'b0;
            rd_valid    <= 1'b0;
        end else begin
            stage_early <= beat_read && cl3;
            rd_valid    <= stage_early || (beat_read && !cl3);
        end
    end

endmodule

// File: rtl/sdram_burst_seq.sv
// Top of the burst column sequencer. It decodes the command, keeps the
// mode register, and drives the beat outputs and the read-valid line.
// Assumes: commands and mode writes are sampled on the rising clock edge,
// and at most one command is presented per cycle.
module sdram_burst_seq
    import sdram_burst_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [2:0]        mode_len_code,
    input  logic              mode_interleave,
    input  logic              mode_cl3,
    input  logic [1:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    output logic              beat_valid,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col,
    output logic              wr_data_valid,
    output logic              rd_data_valid,
    output logic              mode_err
);

    burst_op_e   op;
    logic        cmd_start;
    logic        cmd_stop;
    logic        beat_is_read;
    burst_mode_t mode_cfg;

    // Command decode.
    always_comb begin
        op        = burst_op_e'(cmd_op);
        cmd_start = (op == OP_READ) || (op == OP_WRITE);
        cmd_stop  = (op == OP_TERM);
    end

    sdram_burst_mode u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req       (mode_wr),
        .wr_len_code  (mode_len_code),
        .wr_interleave(mode_interleave),
        .wr_cl3       (mode_cl3),
        .burst_busy   (beat_valid),
        .cmd_starts   (cmd_start),
        .cfg          (mode_cfg),
        .err          (mode_err)
    );

    sdram_burst_addr #(.COL_W(COL_W), .BANK_W(BANK_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .stop      (cmd_stop),
        .start_read(op == OP_READ),
        .start_col (cmd_col),
        .start_bank(cmd_bank),
        .cfg       (mode_cfg),
        .active    (beat_valid),
        .is_read   (beat_is_read),
        .col       (beat_col),
        .bank      (beat_bank)
    );

    sdram_burst_rdpipe u_rdpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_read(beat_valid && beat_is_read),
        .cl3      (mode_cfg.cl3),
        .rd_valid (rd_data_valid)
    );

    // Write data accompanies each write beat with no added delay.
    always_comb begin
        wr_data_valid = beat_valid && !beat_is_read;
    end

endmodule

// File: rtl/sdram_burst_chk.sv
// Checker for the burst column sequencer, bound to the top module.
// It watches the ports and the latency setting.
module sdram_burst_chk #(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_wr,
    input logic [1:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [COL_W-1:0]  cmd_col,
    input logic              beat_valid,
    input logic [BANK_W-1:0] beat_bank,
    input logic [COL_W-1:0]  beat_col,
    input logic              wr_data_valid,
    input logic              rd_data_valid,
    input logic              mode_err,
    input logic              cl3
);

    AST_CMD_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd1 || cmd_op == 2'd2) |=> (beat_valid && beat_col == $past(cmd_col) && beat_bank == $past(cmd_bank))); // R2

    AST_WR_ONLY_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_valid |-> beat_valid); // R2

    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd3) |=> !beat_valid); // R7

    AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && cmd_op == 2'd0) |=> (!beat_valid || beat_bank == $past(beat_bank))); // R9

    AST_RD_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cl3 && beat_valid && !wr_data_valid) |=> rd_data_valid); // R10

    AST_RD_LAT3: assert property (@(posedge clk) disable iff (!rst_n)
        (cl3 && beat_valid && !wr_data_valid) |=> ##1 rd_data_valid); // R10

    AST_MODE_BUSY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && beat_valid) |=> mode_err); // R11

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> $past(mode_wr)); // R12

endmodule

bind sdram_burst_seq sdram_burst_chk #(.COL_W(COL_W), .BANK_W(BANK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_wr      (mode_wr),
    .cmd_op       (cmd_op),
    .cmd_bank     (cmd_bank),
    .cmd_col      (cmd_col),
    .beat_valid   (beat_valid),
    .beat_bank    (beat_bank),
    .beat_col     (beat_col),
    .wr_data_valid(wr_data_valid),
    .rd_data_valid(rd_data_valid),
    .mode_err     (mode_err),
    .cl3          (mode_cfg.cl3)
);

// File: tb/test_sdram_burst_seq.sv
`timescale 1ns/1ps
module test_sdram_burst_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_wr;
    logic [2:0] mode_len_code;
    logic       mode_interleave;
    logic       mode_cl3;
    logic [1:0] cmd_op;
    logic [1:0] cmd_bank;
    logic [7:0] cmd_col;
    logic       beat_valid;
    logic [1:0] beat_bank;
    logic [7:0] beat_col;
    logic       wr_data_valid;
    logic       rd_data_valid;
    logic       mode_err;

    int checks = 0;
    int failures = 0;
    string ctx = "R1";

    // Reference model state
    int m_len = 0, m_il = 0, m_cl3 = 0;
    int b_act = 0, b_idx = 0, b_start = 0, b_bank = 0, b_rd = 0, b_len = 1, b_il = 0;
    int m_err = 0;
    int cyc = 0;
    bit rdsched [0:255];

    always #2.5 clk = ~clk;

    sdram_burst_seq i_sdram_burst_seq (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_len_code(mode_len_code),
        .mode_interleave(mode_interleave), .mode_cl3(mode_cl3), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .beat_valid(beat_valid),
        .beat_bank(beat_bank), .beat_col(beat_col), .wr_data_valid(wr_data_valid),
        .rd_data_valid(rd_data_valid), .mode_err(mode_err)
    );

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_len = 0; m_il = 0; m_cl3 = 0; b_act = 0; b_idx = 0; m_err = 0;
            b_rd = 0; b_len = 1;
            for (int i = 0; i < 256; i++) rdsched[i] = 0;
        end else begin
            int is_cmd, nerr;
            if (b_act != 0 && b_rd != 0) rdsched[(cyc + (m_cl3 != 0 ? 3 : 2) - 1) % 256] = 1;
            is_cmd = (cmd_op == 2'd1 || cmd_op == 2'd2);
            nerr = 0;
            if (mode_wr) begin
                bit ok;
                ok = (mode_len_code <= 3) || (mode_len_code == 7 && !mode_interleave);
                if (b_act != 0 || is_cmd != 0 || !ok) nerr = 1;
                else begin m_len = mode_len_code; m_il = mode_interleave; m_cl3 = mode_cl3; end
            end
            if (is_cmd != 0) begin
                b_act = 1; b_idx = 0; b_start = cmd_col; b_bank = cmd_bank;
                b_rd = (cmd_op == 2'd1);
                b_len = (m_len == 7) ? 256 : (1 << m_len);
                b_il = m_il;
            end else if (cmd_op == 2'd3) begin
                b_act = 0;
            end else if (b_act != 0) begin
                if (b_len != 256 && b_idx == b_len - 1) b_act = 0;
                else b_idx = (b_idx + 1) % 256;
            end
            m_err = nerr;
        end
        cyc++;
        rdsched[(cyc + 128) % 256] = 0;
    end

    function automatic int exp_col();
        int off, base;
        off  = b_start % b_len;
        base = b_start - off;
        if (b_il != 0) return base + (off ^ b_idx);
        return base + ((off + b_idx) % b_len);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s (context %s) actual=%0d expected=%0d at cycle %0d", req, what, ctx, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        chk("R3", "beat_valid", int'(beat_valid), b_act);
        if (b_act != 0) begin
            chk(b_len == 256 ? "R6" : (b_il != 0 ? "R5" : "R4"), "beat_col", int'(beat_col), exp_col());
            chk("R9", "beat_bank", int'(beat_bank), b_bank);
        end
        chk("R2", "wr_data_valid", int'(wr_data_valid), (b_act != 0 && b_rd == 0) ? 1 : 0);
        chk("R10", "rd_data_valid", int'(rd_data_valid), int'(rdsched[cyc % 256]));
        chk(ctx == "R12" ? "R12" : "R11", "mode_err", int'(mode_err), m_err);
    endtask

    task automatic drive(input logic [1:0] op, input logic [1:0] bk, input logic [7:0] col,
                         input logic mw, input logic [2:0] ml, input logic mi, input logic mc);
        @(negedge clk);
        compare_all();
        cmd_op = op; cmd_bank = bk; cmd_col = col;
        mode_wr = mw; mode_len_code = ml; mode_interleave = mi; mode_cl3 = mc;
    endtask

    task automatic cmd(input logic [1:0] op, input logic [1:0] bk, input logic [7:0] col);
        drive(op, bk, col, 1'b0, 3'd0, 1'b0, 1'b0);
    endtask

    task automatic setmode(input logic [2:0] ml, input logic mi, input logic mc);
        drive(2'd0, 2'd0, 8'd0, 1'b1, ml, mi, mc);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cmd(2'd0, 2'd0, 8'd0);
    endtask

    initial begin
        rst_n = 1'b0; mode_wr = 1'b0; mode_len_code = 3'd0; mode_interleave = 1'b0;
        mode_cl3 = 1'b0; cmd_op = 2'd0; cmd_bank = 2'd0; cmd_col = 8'd0;
        repeat (3) @(negedge clk);
        // R1: reset state seen while reset is held
        chk("R1", "beat_valid in reset", int'(beat_valid), 0);
        chk("R1", "rd_data_valid in reset", int'(rd_data_valid), 0);
        chk("R1", "mode_err in reset", int'(mode_err), 0);
        rst_n = 1'b1;

        ctx = "R1"; idle(1);                          // first cycle after release
        ctx = "R2"; cmd(2'd2, 2'd1, 8'd5); idle(3);   // default mode: one write beat
        ctx = "R3"; setmode(3'd2, 1'b0, 1'b0); idle(1);
        cmd(2'd1, 2'd2, 8'd6); idle(6);               // 6,7,4,5 then CL2 valids
        ctx = "R5"; setmode(3'd3, 1'b1, 1'b1); idle(1);
        cmd(2'd1, 2'd3, 8'h2B); idle(11);             // XOR order, CL3
        ctx = "R4"; setmode(3'd1, 1'b0, 1'b0);
        cmd(2'd2, 2'd0, 8'hFF); idle(3);
        ctx = "R6"; setmode(3'd7, 1'b0, 1'b1);
        cmd(2'd2, 2'd1, 8'hFD); idle(6);              // wraps past 255
        ctx = "R7"; cmd(2'd3, 2'd0, 8'd0); idle(3);
        ctx = "R6"; cmd(2'd1, 2'd2, 8'h10); idle(4);
        ctx = "R7"; cmd(2'd3, 2'd0, 8'd0); idle(4);   // trailing read valids
        cmd(2'd3, 2'd0, 8'd0); idle(2);               // terminate while idle
        ctx = "R11"; setmode(3'd3, 1'b0, 1'b0); idle(1);
        cmd(2'd1, 2'd2, 8'h40); idle(1);
        setmode(3'd1, 1'b0, 1'b1); idle(9);           // rejected: beat in progress
        drive(2'd1, 2'd1, 8'h41, 1'b1, 3'd1, 1'b0, 1'b1); idle(10); // rejected: same-cycle command
        ctx = "R12"; setmode(3'd7, 1'b1, 1'b0); setmode(3'd5, 1'b0, 1'b1); idle(2);
        cmd(2'd2, 2'd3, 8'h63); idle(10);             // still 8 beats, sequential
        ctx = "R8"; cmd(2'd1, 2'd1, 8'h50); idle(2);
        cmd(2'd2, 2'd2, 8'h33); idle(2);
        cmd(2'd1, 2'd3, 8'h77); idle(12);
        ctx = "R10"; setmode(3'd3, 1'b0, 1'b1); idle(1);
        cmd(2'd1, 2'd0, 8'h08); idle(1);
        cmd(2'd3, 2'd0, 8'd0); idle(6);
        idle(1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired (context %s) actual=running expected=finished", ctx);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule